// File: doc/BRIEF.md
# ADC Trigger, Channel-Scan and Status Register Front End

This block is the host-facing register set of a multiplexed analog-to-digital converter front end on a 16-bit I/O bus. The host programs a scan range of channels, gain and input-mode bits, and picks what starts a conversion: a host write, a falling or rising edge on an external trigger pin, or a pacer tick. Each start is handed to a stub converter. The stub takes the sample word presented on `adc_sample` and returns a result a fixed number of cycles later. The result is left-justified to 16 bits and handed to a small result FIFO over a valid/ready link.

The FIFO never stalls the converter. When it deasserts ready (full), the result is dropped. The host bus has no back-pressure: every access completes in one cycle, and read data is combinational from the address. The host reads results from the data offset and polls status flags. It clears sticky flags by writing a separate bit map to the status offset. An interrupt request level follows a mode field: never, FIFO not empty, FIFO half full, or end of a scan burst. Bus inputs and the external pins are taken as synchronous to `clk`.

Top module: `adc_front_regs`

## Requirements
- R1: After reset, control reads 0x00 (software trigger), mux reads 0x0000, mode reads 0x60 (gain 0, polled, single-ended, unipolar), status reads 0x00, and `irq_req` is 0.
- R2: With trigger source 0, a write of any value to offset 0x00 starts one conversion. A read of offset 0x00 returns the oldest result and removes it. With any other source, a write to 0x00 adds nothing to the FIFO.
- R3: Control bits 1:0 select the source: 0 software, 1 falling edge of `ext_trig`, 2 rising edge of `ext_trig`, 3 a high cycle of `pacer_tick`. Events of sources that are not selected start nothing.
- R4: Mux offset 0x02 holds the first channel in bits 5:0 and the last channel in bits 13:8, and reads back the written word. Writing it restarts the scan at the first channel. Successive conversions step the channel by one and return to the first channel after the last. The channel in use appears on `conv_chan` while `conv_busy` is 1.
- R5: With mode bit 5 (single-ended) at 0, the converted channel has its top bit forced to 0.
- R6: A result is the low RES_BITS bits of `adc_sample` shifted left by 16-RES_BITS, with zero low bits.
- R7: The FIFO holds FIFO_DEPTH results in order. Status bit0 means not empty, bit1 means at least half full, and bit2 means full. A result arriving when the FIFO is full is dropped. A read of 0x00 when the FIFO is empty returns 0.
- R8: Status bit4 is set by each result the FIFO accepts. Bit5 is set by a selected external edge. Bit3 is set by a rising edge on `ext_irq`.
- R9: A status write with bit0 set clears bit4 and the end-of-burst flag; bit1 clears bit5; bit2 clears bit3. A new set in the same cycle wins over the clear. Every status write loads its bit7 into status bit7.
- R10: `irq_req` follows mode bits 3:2: 0 gives 0, 1 gives FIFO not empty, 2 gives half full, and 3 gives the end-of-burst flag, which is set when the result of the last scan channel is accepted.
- R11: A start event that arrives while a conversion is running is ignored.
- R12: Control (offset 0x09, 8 bits) and mode (offset 0x0B, 7 bits) read back as written. Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of offset 0x00 pops the FIFO |
| bus_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| ext_trig | input | 1 | External trigger pin |
| pacer_tick | input | 1 | Pacer start pulse |
| ext_irq | input | 1 | External interrupt pin |
| adc_sample | input | 16 | Sample value taken by the stub converter at start |
| conv_busy | output | 1 | Conversion in progress |
| conv_chan | output | 6 | Channel of the running conversion |
| irq_req | output | 1 | Interrupt request level per mode |

## Verification
The hardest state to reach is a full FIFO that takes one more result. That result must be dropped, and the flags and contents must show it. The bench gets there by firing software conversions one after another, without reading, while it tracks its own occupancy model. It checks the half and full flags on the way up. It then fires one conversion beyond capacity and drains the FIFO against the scoreboard, so a wrongly accepted ninth result would show up as a mismatch. End-of-burst interrupts need a scan that reaches its last channel. The bench sets a one-channel range so that every result closes a burst, and then checks that only a status write clears the flag.

// File: rtl/adc_front_pkg.sv
package adc_front_pkg;
  localparam int CHAN_W = 6;
  localparam int WORD_W = 16;

  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_MUX  = 4'h2;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_CTRL = 4'h9;
  localparam logic [3:0] OFS_MODE = 4'hB;

  typedef enum logic [1:0] {
    TRIG_SOFT = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_PACE = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    IRQ_POLL  = 2'd0,
    IRQ_AVAIL = 2'd1,
    IRQ_HALF  = 2'd2,
    IRQ_BURST = 2'd3
  } irq_mode_e;

  typedef struct packed {
    logic clk_sel;
    logic xtrig;
    logic cint;
    logic xint;
    logic eob;
  } flags_t;

  // Left-justify the low 'bits' bits of a sample into a 16-bit word.
  function automatic logic [WORD_W-1:0] justify(input logic [WORD_W-1:0] s, input int bits);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++)
      if (i < bits) m[i] = s[i];
    return m << (WORD_W - bits);
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_front_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trig_src_e src,
  input  logic      sw_hit,
  input  logic      ext_trig,
  input  logic      pacer_tick,
  input  logic      ext_irq,
  output logic      trig_req,
  output logic      xtrig_hit,
  output logic      xint_rise
);
  logic trig_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      trig_q <= ext_trig;
      irq_q  <= ext_irq;
    end
  end

  logic rise, fall;
  assign rise      = ext_trig && !trig_q;
  assign fall      = !ext_trig && trig_q;
  assign xint_rise = ext_irq && !irq_q;

  always_comb begin
    trig_req  = 1'b0;
    xtrig_hit = 1'b0;
    unique case (src)
      TRIG_SOFT: trig_req = sw_hit;
      TRIG_FALL: begin trig_req = fall; xtrig_hit = fall; end
      TRIG_RISE: begin trig_req = rise; xtrig_hit = rise; end
      TRIG_PACE: trig_req = pacer_tick;
    endcase
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
  import adc_front_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int CONV_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              last_in,
  input  logic [WORD_W-1:0] sample,
  output logic              busy,
  output logic [CHAN_W-1:0] chan_out,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  output logic              res_last
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy      = busy_q;
  assign res_valid = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      chan_out <= '0;
      res_data <= '0;
      res_last <= 1'b0;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      cnt_q    <= CW'(CONV_CYCLES - 1);
      chan_out <= chan_in;
      res_last <= last_in;
      res_data <= justify(sample, RES_BITS);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo
  import adc_front_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [WORD_W-1:0]          in_data,
  input  logic                       pop,
  output logic [WORD_W-1:0]          out_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       not_empty,
  output logic                       half,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [NW-1:0]     cnt_q;
  logic              do_push, do_pop;

  assign full      = (cnt_q == NW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign half      = (cnt_q >= NW'(DEPTH / 2));
  assign in_ready  = !full;
  assign do_push   = in_valid && in_ready;
  assign do_pop    = pop && not_empty;
  assign out_data  = mem[rp_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/adc_front_regs.sv
module adc_front_regs
  import adc_front_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int FIFO_DEPTH  = 8,
  parameter int CONV_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ext_trig,
  input  logic              pacer_tick,
  input  logic              ext_irq,
  input  logic [WORD_W-1:0] adc_sample,
  output logic              conv_busy,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              irq_req
);
  localparam int NW = $clog2(FIFO_DEPTH + 1);
  localparam logic [6:0] MODE_RST = 7'h60;

  // register state
  logic [7:0]        ctrl_q;
  logic [6:0]        mode_q;
  logic [WORD_W-1:0] mux_q;
  logic [CHAN_W-1:0] scan_q;
  flags_t            flg_q;

  logic wr_data, wr_mux, wr_stat, wr_ctrl, wr_mode, rd_data;
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_mux  = bus_wr && (bus_addr == OFS_MUX);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  logic [CHAN_W-1:0] first_ch, last_ch;
  assign first_ch = mux_q[CHAN_W-1:0];
  assign last_ch  = mux_q[8 +: CHAN_W];

  // trigger selection
  logic trig_req, xtrig_hit, xint_rise, conv_start;
  adc_trig_sel u_trig (
    .clk(clk), .rst_n(rst_n), .src(trig_src_e'(ctrl_q[1:0])), .sw_hit(wr_data),
    .ext_trig(ext_trig), .pacer_tick(pacer_tick), .ext_irq(ext_irq),
    .trig_req(trig_req), .xtrig_hit(xtrig_hit), .xint_rise(xint_rise)
  );
  assign conv_start = trig_req && !conv_busy;

  // channel pick: differential mode keeps the lower half of the channel space
  logic [CHAN_W-1:0] pick_ch;
  logic              pick_last;
  always_comb begin
    pick_ch = scan_q;
    if (!mode_q[5]) pick_ch[CHAN_W-1] = 1'b0;
    pick_last = (scan_q == last_ch);
  end

  // converter and result link
  logic              res_valid, res_ready, res_last, push_acc;
  logic [WORD_W-1:0] res_data, fifo_head;
  logic [NW-1:0]     fifo_count;
  logic              st_ne, st_half, st_full;

  adc_conv_stub #(.RES_BITS(RES_BITS), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .chan_in(pick_ch),
    .last_in(pick_last), .sample(adc_sample), .busy(conv_busy), .chan_out(conv_chan),
    .res_valid(res_valid), .res_data(res_data), .res_last(res_last)
  );

  adc_res_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(res_valid), .in_ready(res_ready),
    .in_data(res_data), .pop(rd_data), .out_data(fifo_head), .count(fifo_count),
    .not_empty(st_ne), .half(st_half), .full(st_full)
  );
  assign push_acc = res_valid && res_ready;

  // control, mode, mux, scan
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mode_q <= MODE_RST;
      mux_q  <= '0;
      scan_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[7:0];
      if (wr_mode) mode_q <= bus_wdata[6:0];
      if (wr_mux) begin
        mux_q  <= bus_wdata;
        scan_q <= bus_wdata[CHAN_W-1:0];
      end else if (conv_start) begin
        scan_q <= pick_last ? first_ch : scan_q + 1'b1;
      end
    end
  end

  // sticky flags: a set in the same cycle wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      if (push_acc)                     flg_q.cint <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flg_q.cint <= 1'b0;
      if (push_acc && res_last)         flg_q.eob  <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flg_q.eob  <= 1'b0;
      if (xtrig_hit)                    flg_q.xtrig <= 1'b1;
      else if (wr_stat && bus_wdata[1]) flg_q.xtrig <= 1'b0;
      if (xint_rise)                    flg_q.xint <= 1'b1;
      else if (wr_stat && bus_wdata[2]) flg_q.xint <= 1'b0;
      if (wr_stat)                      flg_q.clk_sel <= bus_wdata[7];
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = st_ne ? fifo_head : '0;
      OFS_MUX:  bus_rdata = mux_q;
      OFS_STAT: bus_rdata = {8'h00, flg_q.clk_sel, 1'b0, flg_q.xtrig, flg_q.cint,
                             flg_q.xint, st_full, st_half, st_ne};
      OFS_CTRL: bus_rdata = {8'h00, ctrl_q};
      OFS_MODE: bus_rdata = {9'h000, mode_q};
      default:  bus_rdata = '0;
    endcase
  end

  // interrupt request level
  always_comb begin
    unique case (irq_mode_e'(mode_q[3:2]))
      IRQ_POLL:  irq_req = 1'b0;
      IRQ_AVAIL: irq_req = st_ne;
      IRQ_HALF:  irq_req = st_half;
      IRQ_BURST: irq_req = flg_q.eob;
    endcase
  end
endmodule

// File: rtl/adc_front_chk.sv
module adc_front_chk
  import adc_front_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [3:0]                      bus_addr,
  input logic                            bus_wr,
  input logic                            bus_rd,
  input logic [WORD_W-1:0]               bus_wdata,
  input logic [WORD_W-1:0]               bus_rdata,
  input logic                            conv_start,
  input logic                            conv_busy,
  input logic [CHAN_W-1:0]               conv_chan,
  input logic [6:0]                      mode_q,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count,
  input logic                            push_acc,
  input logic                            cint,
  input logic                            st_ne,
  input logic                            st_half,
  input logic                            st_full,
  input logic                            irq_req
);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= FIFO_DEPTH);

  p_full_nesting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_full |-> (st_half && st_ne));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_DATA && !st_ne) |-> (bus_rdata == '0));

  p_push_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> cint);

  p_clear_cint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT && bus_wdata[0] && !push_acc) |=> !cint);

  p_diff_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !mode_q[5]) |=> !conv_chan[CHAN_W-1]);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> conv_busy);

  p_irq_polled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3:2] == 2'b00) |-> !irq_req);
endmodule

bind adc_front_regs adc_front_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
  .conv_busy(conv_busy), .conv_chan(conv_chan), .mode_q(mode_q),
  .fifo_count(fifo_count), .push_acc(push_acc), .cint(flg_q.cint),
  .st_ne(st_ne), .st_half(st_half), .st_full(st_full), .irq_req(irq_req)
);

// File: tb/adc_front_regs_test.sv
module adc_front_regs_test;
  localparam int RES_BITS = 12;
  localparam int DEPTH    = 8;
  localparam int CONV     = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_trig = 1'b0, pacer_tick = 1'b0, ext_irq = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        conv_busy;
  logic [5:0]  conv_chan;
  logic        irq_req;

  int total = 0;
  int bad = 0;
  int model_cnt = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  adc_front_regs #(.RES_BITS(RES_BITS), .FIFO_DEPTH(DEPTH), .CONV_CYCLES(CONV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .pacer_tick(pacer_tick), .ext_irq(ext_irq), .adc_sample(adc_sample),
    .conv_busy(conv_busy), .conv_chan(conv_chan), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] just(input logic [15:0] s);
    return {s[11:0], 4'h0};
  endfunction

  // driver: record the expected result when the bench model has room
  task automatic expect_push(input logic [15:0] s);
    if (model_cnt < DEPTH) begin
      exp_q.push_back(just(s));
      model_cnt++;
    end
  endtask

  task automatic sw_conv(input logic [15:0] s);
    adc_sample = s;
    wr(4'h0, 16'h0);
    expect_push(s);
    idle(CONV + 2);
  endtask

  // monitor: pop results from the design and compare against the scoreboard
  task automatic drain(input string req);
    logic [15:0] st, d, e;
    rd(4'h8, st);
    while (st[0]) begin
      rd(4'h0, d);
      if (exp_q.size() == 0) begin
        check(req, d, 16'hxxxx);
      end else begin
        e = exp_q.pop_front();
        check(req, d, e);
      end
      rd(4'h8, st);
    end
    check({req, " scoreboard empty"}, 16'(exp_q.size()), 16'd0);
    model_cnt = 0;
  endtask

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(4'h9, v); check("R1 ctrl", v, 16'h0000);
    rd(4'h2, v); check("R1 mux", v, 16'h0000);
    rd(4'hB, v); check("R1 mode", v, 16'h0060);
    rd(4'h8, v); check("R1 status", v, 16'h0000);
    check("R1 irq", {15'd0, irq_req}, 16'd0);

    // R2 R6 software conversions, left-justified
    sw_conv(16'h0ABC);
    sw_conv(16'hF123);
    sw_conv(16'h0FFF);
    rd(4'h8, v); check("R8 cint after push", v & 16'h0011, 16'h0011);
    drain("R2 R6 software results");
    wr(4'h8, 16'h0001);
    rd(4'h8, v); check("R9 cint cleared", v & 16'h0010, 16'h0000);

    // R11 second start while busy is ignored
    adc_sample = 16'h0111;
    wr(4'h0, 16'h0);
    wr(4'h0, 16'h0);
    expect_push(16'h0111);
    idle(CONV + 2);
    drain("R11 busy start ignored");

    // R3 rising source; data writes do nothing
    wr(4'h9, 16'h0002);
    wr(4'h0, 16'h0);
    idle(CONV + 2);
    rd(4'h8, v); check("R2 write ignored off software", v & 16'h0001, 16'h0000);
    adc_sample = 16'h0222;
    @(negedge clk) ext_trig = 1'b1;
    expect_push(16'h0222);
    idle(CONV + 2);
    rd(4'h8, v); check("R8 xtrig seen", v & 16'h0020, 16'h0020);
    drain("R3 rising edge result");
    // falling source: rising edge ignored, falling edge converts
    wr(4'h9, 16'h0001);
    @(negedge clk) ext_trig = 1'b0;
    adc_sample = 16'h0333;
    expect_push(16'h0333);
    idle(CONV + 2);
    @(negedge clk) ext_trig = 1'b1;
    idle(CONV + 2);
    drain("R3 falling edge result");
    @(negedge clk) ext_trig = 1'b0;
    expect_push(16'h0333);
    idle(CONV + 2);
    drain("R3 falling edge second");
    // pacer source
    wr(4'h9, 16'h0003);
    adc_sample = 16'h0444;
    @(negedge clk) pacer_tick = 1'b1;
    @(negedge clk) pacer_tick = 1'b0;
    expect_push(16'h0444);
    idle(CONV + 2);
    drain("R3 pacer result");
    wr(4'h9, 16'h0000);

    // R4 scan 3..5 wraps
    wr(4'h2, 16'h0503);
    rd(4'h2, v); check("R4 mux readback", v, 16'h0503);
    for (int i = 0; i < 4; i++) begin
      adc_sample = 16'(16'h0100 + i);
      wr(4'h0, 16'h0);
      check("R4 scan channel", {10'd0, conv_chan}, 16'(3 + (i % 3)));
      expect_push(16'(16'h0100 + i));
      idle(CONV + 2);
    end
    drain("R4 scan results");

    // R5 differential masks top channel bit
    wr(4'hB, 16'h0040);
    wr(4'h2, 16'h2828);
    sw_conv(16'h0555);
    check("R5 diff channel", {10'd0, conv_chan}, 16'd8);
    drain("R5 diff result");
    wr(4'hB, 16'h0060);
    wr(4'h2, 16'h0000);

    // R7 fill, half, full, overflow drop, empty read
    for (int i = 0; i < DEPTH; i++) begin
      sw_conv(16'(16'h0A00 + i));
      if (i == DEPTH / 2 - 1) begin
        rd(4'h8, v); check("R7 half flag", v & 16'h0007, 16'h0003);
      end
    end
    rd(4'h8, v); check("R7 full flag", v & 16'h0007, 16'h0007);
    sw_conv(16'h0BAD);
    rd(4'h8, v); check("R7 full after drop", v & 16'h0007, 16'h0007);
    drain("R7 order and drop");
    rd(4'h0, v); check("R7 empty read", v, 16'h0000);

    // R8 R9 external interrupt flag and clears
    @(negedge clk) ext_irq = 1'b1;
    @(negedge clk) ext_irq = 1'b0;
    rd(4'h8, v); check("R8 xint set", v & 16'h0038, 16'h0038);
    wr(4'h8, 16'h0002);
    rd(4'h8, v); check("R9 clear xtrig only", v & 16'h0038, 16'h0018);
    wr(4'h8, 16'h0007);
    rd(4'h8, v); check("R9 clear all", v, 16'h0000);
    wr(4'h8, 16'h0080);
    rd(4'h8, v); check("R9 clock select", v, 16'h0080);

    // R10 interrupt modes
    wr(4'hB, 16'h0064);
    sw_conv(16'h0001);
    check("R10 avail irq", {15'd0, irq_req}, 16'd1);
    drain("R10 avail drain");
    check("R10 avail irq low", {15'd0, irq_req}, 16'd0);
    wr(4'hB, 16'h0068);
    for (int i = 0; i < 3; i++) sw_conv(16'(i));
    check("R10 half irq low", {15'd0, irq_req}, 16'd0);
    sw_conv(16'h0003);
    check("R10 half irq", {15'd0, irq_req}, 16'd1);
    drain("R10 half drain");
    wr(4'h8, 16'h0001);
    wr(4'hB, 16'h006C);
    sw_conv(16'h0007);
    drain("R10 burst drain");
    check("R10 burst irq sticky", {15'd0, irq_req}, 16'd1);
    wr(4'h8, 16'h0001);
    check("R10 burst irq cleared", {15'd0, irq_req}, 16'd0);

    // R12 readback
    wr(4'hB, 16'h007F);
    rd(4'hB, v); check("R12 mode readback", v, 16'h007F);
    wr(4'h9, 16'h00B4);
    rd(4'h9, v); check("R12 ctrl readback", v, 16'h00B4);
    rd(4'hA, v); check("R12 unused offset", v, 16'h0000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule